// File: doc/BRIEF.md
# Bit-Serial Port Transfer Datapath

This block is the storage and routing half of a small bit-serial computer with a 12-bit word. It keeps three recirculating stores: a data line and an instruction line of 32 words each, and a one-word accumulator. Each store is a shift register that feeds its own output back to its input on every bit clock. A word in a long line reaches the head once per major cycle of 32 word cycles. The accumulator comes round once per word cycle.

A controller outside this block decodes instructions and times them. It drives a one-hot bit-phase vector, a transfer window that spans one whole word, and 3-bit source and destination selects. During the window, the selected source streams one bit per clock, least significant bit first, into the selected destination. Every operation of the machine is such a pair of ports. The sources include two constant generators, a view of the accumulator that keeps only its sign bit, and a ready flag. The destinations include an add-into-accumulator port that is built on a serial full adder. The controller receives the instruction line as a serial stream. It can also receive any source in place of that stream.

Top module: `ser_port_datapath`

## Requirements
- R1: After reset, the data line, the instruction line, the accumulator and the output latch all hold zero.
- R2: Each long line holds 32 words. A transfer touches only the word that is at the head of the line during that window. Every other word, and the written word in later major cycles, keeps its value. Bit k of a word travels during phase k, so bit 0 is at phase 0 and bit 11 is at phase 11.
- R3: Destination 2 overwrites the accumulator with the source word. Source 3 reads the accumulator without changing it.
- R4: Destination 3 adds the source word into the accumulator modulo 2^12. The carry out of bit 11 is dropped, and no carry passes from one word into the next.
- R5: Source 4 supplies the constant 32, which is a one at bit 5 only. Source 5 supplies the constant 1, which is a one at bit 0 only.
- R6: Source 2 supplies the accumulator with every bit except bit 11 forced to zero. The pair 5→2 followed by 2→2 leaves the accumulator at zero.
- R7: Source 0 supplies the parallel input word as it stands at the first phase of the window. Source 7 supplies the ready flag in bit 0 and zeros elsewhere.
- R8: Destination 0 loads the output word at the end of the window. The output word holds its value through every window that has another destination.
- R9: Destination 5 writes the instruction line and source 6 reads it. Outside a transfer to destination 6, the serial instruction output carries the head bit of the instruction line.
- R10: During a transfer to destination 6, the serial instruction output carries the source bits in place of the line, and no store changes.
- R11: A transfer to destination 4 raises the special strobe for exactly one clock, during the last phase of the window.
- R12: Destination 7 discards its data: the stores and the output word are unchanged.
- R13: A transfer from the data line to the data line leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset; clears every store |
| phase | input | 12 | One-hot bit phase; bit k is high while word bit k is in flight |
| xfer | input | 1 | Transfer window, high for the 12 phases of one word |
| src_sel | input | 3 | Source port select |
| dst_sel | input | 3 | Destination port select |
| in_word | input | 12 | Parallel input word for source 0 |
| io_ready | input | 1 | Ready flag for source 7 |
| out_word | output | 12 | Output latch written by destination 0 |
| instr_bit | output | 1 | Serial instruction stream to the controller |
| special_strobe | output | 1 | One-clock trigger for destination 4 |

## Verification
Every store can only be seen through another transfer. So a wrong bit in a long line stays hidden until the bench reads that same word position, which can be up to a full major cycle of 384 clocks later. A wrong accumulator bit shows up in the next readout, and it also spreads through later adds. A phase slip or a carry that is never cleared shows up as a shifted or off-by-one value in the output word at the end of the window that reads it out. Because of this, each test ends with a read of the state it could have disturbed.

// File: rtl/ser_dp_pkg.sv
package ser_dp_pkg;

   // source port numbers
   typedef enum logic [2:0] {
      SRC_INPUT = 3'd0,
      SRC_DATA  = 3'd1,
      SRC_SIGN  = 3'd2,
      SRC_ACC   = 3'd3,
      SRC_K32   = 3'd4,
      SRC_K1    = 3'd5,
      SRC_INSTR = 3'd6,
      SRC_READY = 3'd7
   } src_port_e;

   // destination port numbers
   typedef enum logic [2:0] {
      DST_OUTPUT  = 3'd0,
      DST_DATA    = 3'd1,
      DST_ACC_SET = 3'd2,
      DST_ACC_ADD = 3'd3,
      DST_SPECIAL = 3'd4,
      DST_INSTR   = 3'd5,
      DST_IR      = 3'd6,
      DST_NULL    = 3'd7
   } dst_port_e;

   // phase index that carries the constant-32 pulse
   localparam int K32_PHASE = 5;

endpackage

// File: rtl/ser_delay_line.sv
module ser_delay_line #(
   parameter int LEN_BITS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic head
);
   logic [LEN_BITS-1:0] sr;
   logic                nxt;

   assign head = sr[0];
   assign nxt  = wr_en ? wr_bit : sr[0];

   generate
      if (LEN_BITS < 1) begin : g_bad
         $error("ser_delay_line: LEN_BITS must be positive");
      end
      if (LEN_BITS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= nxt;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {nxt, sr[LEN_BITS-1:1]};
         end
      end
   endgenerate

endmodule

// File: rtl/ser_full_adder.sv
module ser_full_adder (
   input  logic clk,
   input  logic rst_n,
   input  logic first_bit,
   input  logic a,
   input  logic b,
   output logic sum
);
   logic carry_q;
   logic cin;

   assign cin = first_bit ? 1'b0 : carry_q;
   assign sum = a ^ b ^ cin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= 1'b0;
      else        carry_q <= (a & b) | (a & cin) | (b & cin);
   end

   // R4: the first bit of a word never sees a carry left over from the last word
   // R4
   carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_bit |-> (sum == (a ^ b)));

endmodule

// File: rtl/ser_io_ports.sv
module ser_io_ports #(
   parameter int WB = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [WB-1:0] phase,
   input  logic          in_cap_en,
   input  logic [WB-1:0] in_word,
   output logic          in_bit,
   input  logic          out_we,
   input  logic          out_src_bit,
   output logic [WB-1:0] out_word
);
   localparam int IDXW = $clog2(WB);

   logic [IDXW-1:0] bit_idx;
   logic [WB-1:0]   in_cap;
   logic [WB-1:0]   col;

   always_comb begin
      bit_idx = '0;
      for (int i = 0; i < WB; i++)
         if (phase[i]) bit_idx = IDXW'(i);
   end

   // input is sampled at the first phase; bit 0 passes straight through
   assign in_bit = phase[0] ? in_word[0] : in_cap[bit_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      in_cap <= '0;
      else if (in_cap_en && phase[0])  in_cap <= in_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col      <= '0;
         out_word <= '0;
      end else if (out_we) begin
         if (phase[WB-1]) out_word     <= {out_src_bit, col[WB-2:0]};
         else             col[bit_idx] <= out_src_bit;
      end
   end

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(out_we && phase[WB-1]) |-> $stable(out_word));

endmodule

// File: rtl/ser_port_datapath.sv
module ser_port_datapath
   import ser_dp_pkg::*;
#(
   parameter int WB    = 12,
   parameter int WORDS = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [WB-1:0] phase,
   input  logic          xfer,
   input  logic [2:0]    src_sel,
   input  logic [2:0]    dst_sel,
   input  logic [WB-1:0] in_word,
   input  logic          io_ready,
   output logic [WB-1:0] out_word,
   output logic          instr_bit,
   output logic          special_strobe
);
   localparam int LINE_BITS = WB * WORDS;

   generate
      if (WB <= K32_PHASE + 1) begin : g_wb_chk
         $error("ser_port_datapath: WB too small for the constant and sign ports");
      end
      if (WORDS < 2) begin : g_words_chk
         $error("ser_port_datapath: WORDS must be at least 2");
      end
   endgenerate

   logic data_head, instr_head, acc_head;
   logic in_bit, src_bit, sum_bit;
   logic data_we, instr_we, acc_we, acc_wbit, out_we;

   // source selection
   always_comb begin
      unique case (src_sel)
         SRC_INPUT: src_bit = in_bit;
         SRC_DATA:  src_bit = data_head;
         SRC_SIGN:  src_bit = acc_head & phase[WB-1];
         SRC_ACC:   src_bit = acc_head;
         SRC_K32:   src_bit = phase[K32_PHASE];
         SRC_K1:    src_bit = phase[0];
         SRC_INSTR: src_bit = instr_head;
         default:   src_bit = io_ready & phase[0];
      endcase
   end

   // destination enables
   assign data_we  = xfer && (dst_sel == DST_DATA);
   assign instr_we = xfer && (dst_sel == DST_INSTR);
   assign acc_we   = xfer && ((dst_sel == DST_ACC_SET) || (dst_sel == DST_ACC_ADD));
   assign acc_wbit = (dst_sel == DST_ACC_ADD) ? sum_bit : src_bit;
   assign out_we   = xfer && (dst_sel == DST_OUTPUT);

   assign instr_bit      = (xfer && (dst_sel == DST_IR)) ? src_bit : instr_head;
   assign special_strobe = xfer && (dst_sel == DST_SPECIAL) && phase[WB-1];

   ser_delay_line #(.LEN_BITS(LINE_BITS)) u_data_line (
      .clk(clk), .rst_n(rst_n), .wr_en(data_we), .wr_bit(src_bit), .head(data_head));

   ser_delay_line #(.LEN_BITS(LINE_BITS)) u_instr_line (
      .clk(clk), .rst_n(rst_n), .wr_en(instr_we), .wr_bit(src_bit), .head(instr_head));

   ser_delay_line #(.LEN_BITS(WB)) u_acc_line (
      .clk(clk), .rst_n(rst_n), .wr_en(acc_we), .wr_bit(acc_wbit), .head(acc_head));

   ser_full_adder u_adder (
      .clk(clk), .rst_n(rst_n), .first_bit(phase[0]),
      .a(acc_head), .b(src_bit), .sum(sum_bit));

   ser_io_ports #(.WB(WB)) u_io (
      .clk(clk), .rst_n(rst_n), .phase(phase),
      .in_cap_en(xfer && (src_sel == SRC_INPUT)), .in_word(in_word), .in_bit(in_bit),
      .out_we(out_we), .out_src_bit(src_bit), .out_word(out_word));

   // R2
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase) == 1);

   // R11
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      special_strobe |=> !special_strobe);

   // R5 R6
   idle_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_sel == SRC_SIGN || src_sel == SRC_K32 || src_sel == SRC_K1) &&
       !phase[0] && !phase[K32_PHASE] && !phase[WB-1]) |-> !src_bit);

   // R10
   ir_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && dst_sel == DST_IR && src_sel == SRC_K1 && !phase[0]) |-> !instr_bit);

endmodule

// File: tb/ser_port_datapath_bench.sv
module ser_port_datapath_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] phase = 12'h001;
   logic        xfer = 1'b0;
   logic [2:0]  src_sel = 3'd0, dst_sel = 3'd7;
   logic [11:0] in_word = 12'h000;
   logic        io_ready = 1'b0;
   logic [11:0] out_word;
   logic        instr_bit, special_strobe;

   int errors = 0, checks = 0, cycles = 0;
   int bitn = 0, wordn = 0;

   always #2.5 clk = ~clk;

   ser_port_datapath u_ser_port_datapath (
      .clk(clk), .rst_n(rst_n), .phase(phase), .xfer(xfer),
      .src_sel(src_sel), .dst_sel(dst_sel), .in_word(in_word), .io_ready(io_ready),
      .out_word(out_word), .instr_bit(instr_bit), .special_strobe(special_strobe));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      bitn = (bitn + 1) % 12;
      if (bitn == 0) wordn = (wordn + 1) % 32;
      phase = 12'h001 << bitn;
   endtask

   // one word transfer at line position pos; returns serial instr bits and strobe count
   task automatic xw(input logic [2:0] s, input logic [2:0] d, input int pos,
                     output logic [11:0] ibits, output int strobes);
      while (!(bitn == 0 && wordn == pos)) tick();
      src_sel = s; dst_sel = d; xfer = 1'b1; ibits = '0; strobes = 0;
      for (int k = 0; k < 12; k++) begin
         #1;
         ibits[k] = instr_bit;
         if (special_strobe) strobes++;
         tick();
      end
      xfer = 1'b0;
   endtask

   task automatic mv(input logic [2:0] s, input logic [2:0] d, input int pos);
      logic [11:0] ib; int st;
      xw(s, d, pos, ib, st);
   endtask

   task automatic put(input logic [11:0] v, input logic [2:0] d, input int pos);
      in_word = v;
      mv(3'd0, d, pos);
      in_word = 12'h000;
   endtask

   task automatic rd(input logic [2:0] s, input int pos, output logic [11:0] v);
      mv(s, 3'd0, pos);
      v = out_word;
   endtask

   task automatic t_reset();
      logic [11:0] v;
      chk("R1 out latch", out_word, 12'h000);
      rd(3'd3, 1, v); chk("R1 acc", v, 12'h000);
      rd(3'd1, 5, v); chk("R1 data line", v, 12'h000);
      rd(3'd6, 9, v); chk("R1 instr line", v, 12'h000);
   endtask

   task automatic t_data_line();
      logic [11:0] v;
      put(12'hA5C, 3'd1, 3);
      put(12'h13B, 3'd1, 4);
      rd(3'd1, 3, v); chk("R2 word 3", v, 12'hA5C);
      rd(3'd1, 4, v); chk("R2 word 4", v, 12'h13B);
      rd(3'd1, 5, v); chk("R2 neighbour word 5", v, 12'h000);
   endtask

   task automatic t_acc();
      logic [11:0] v;
      put(12'h123, 3'd2, 0);
      rd(3'd3, 1, v); chk("R3 acc overwrite", v, 12'h123);
      rd(3'd3, 2, v); chk("R3 acc read twice", v, 12'h123);
      put(12'h0FF, 3'd3, 3);
      rd(3'd3, 4, v); chk("R4 add", v, 12'h222);
   endtask

   task automatic t_overflow();
      logic [11:0] v;
      put(12'hFFF, 3'd2, 6);
      mv(3'd5, 3'd3, 7);
      rd(3'd3, 8, v); chk("R4 overflow dropped", v, 12'h000);
      mv(3'd5, 3'd3, 9);
      rd(3'd3, 10, v); chk("R4 no carry across words", v, 12'h001);
   endtask

   task automatic t_consts();
      logic [11:0] v;
      rd(3'd4, 11, v); chk("R5 const 32", v, 12'h020);
      rd(3'd5, 12, v); chk("R5 const 1", v, 12'h001);
   endtask

   task automatic t_sign();
      logic [11:0] v;
      put(12'h8A1, 3'd2, 13);
      rd(3'd2, 14, v); chk("R6 sign negative", v, 12'h800);
      put(12'h7FF, 3'd2, 15);
      rd(3'd2, 16, v); chk("R6 sign positive", v, 12'h000);
      put(12'hABC, 3'd2, 17);
      mv(3'd5, 3'd2, 18);
      mv(3'd2, 3'd2, 19);
      rd(3'd3, 20, v); chk("R6 clear pair", v, 12'h000);
   endtask

   task automatic t_input_ready();
      logic [11:0] v;
      io_ready = 1'b1;
      rd(3'd7, 21, v); chk("R7 ready set", v, 12'h001);
      io_ready = 1'b0;
      rd(3'd7, 22, v); chk("R7 ready clear", v, 12'h000);
      put(12'h6E9, 3'd0, 23);
      chk("R7 input word to output", out_word, 12'h6E9);
   endtask

   task automatic t_instr();
      logic [11:0] v, ib; int st;
      put(12'h3C7, 3'd5, 7);
      rd(3'd6, 7, v); chk("R9 instr readback", v, 12'h3C7);
      rd(3'd6, 8, v); chk("R9 instr neighbour", v, 12'h000);
      xw(3'd7, 3'd7, 7, ib, st);
      chk("R9 instr stream", ib, 12'h3C7);
      chk("R12 out unchanged by discard", out_word, 12'h000);
   endtask

   task automatic t_ir_route();
      logic [11:0] v, ib; int st;
      put(12'h5A5, 3'd2, 24);
      xw(3'd3, 3'd6, 7, ib, st);
      chk("R10 routed to instr stream", ib, 12'h5A5);
      rd(3'd6, 7, v); chk("R10 instr line untouched", v, 12'h3C7);
      rd(3'd3, 8, v); chk("R10 acc untouched", v, 12'h5A5);
   endtask

   task automatic t_special_discard();
      logic [11:0] v, ib; int st;
      xw(3'd3, 3'd4, 9, ib, st);
      chk("R11 strobe count", 12'(st), 12'h001);
      chk("R8 out held after special", out_word, 12'h5A5);
      mv(3'd5, 3'd7, 10);
      chk("R12 out held after discard", out_word, 12'h5A5);
      rd(3'd3, 11, v); chk("R12 acc unchanged", v, 12'h5A5);
   endtask

   task automatic t_self();
      logic [11:0] v;
      mv(3'd1, 3'd1, 3);
      rd(3'd1, 3, v); chk("R13 self copy", v, 12'hA5C);
      rd(3'd1, 4, v); chk("R2 word 4 after major cycles", v, 12'h13B);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_data_line();
      t_acc();
      t_overflow();
      t_consts();
      t_sign();
      t_input_ready();
      t_instr();
      t_ir_route();
      t_special_discard();
      t_self();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule